// File: doc/BRIEF.md
# Serial Configuration Register with Readback Stream

This block holds the 12-bit configuration word of a current-input converter. The word is loaded over a dedicated serial write port and can be streamed back out on a separate read port. A host opens a configuration session by pulsing the arm strobe while the acquisition-control input is held low. It then clocks the word in, most significant bit first, on the falling edges of the write clock. The new value takes effect only if the write was complete. A rising edge on the acquisition-control input closes the session and returns the device to normal operation.

While the session is open, every rising edge of the read clock moves the next bit of a readback stream onto the read data output. The stream is one frame sent twice. Each frame holds three parts in order: the word just shifted in, a 4-bit revision ID, and a fixed test pattern. The pattern is zero-padded, and its length is set by bit 11 of the written word. Once both frames have been sent, the output passes on a daisy-chain input, delayed by one read clock. This lets several devices be read in series.

All serial inputs are taken as levels that are synchronous to the block clock `clk`. Edges on them are detected internally.

Top module: `cfgreg_serial`

## Requirements
- R1: A rising edge on `arm_strobe_i` while `acq_ctl_i` is low opens a session. Opening clears the write bit count, the shift register and the readback position. A rising edge on `arm_strobe_i` while `acq_ctl_i` is high opens nothing.
- R2: In a session, each falling edge of `wr_clk_i` shifts `wr_dat_i` into the write shift register, most significant bit first. The first bit sent becomes configuration bit 11.
- R3: A rising edge of `acq_ctl_i` closes the session. It copies the shift register into `cfg_word_o` only when exactly 12 write-clock falling edges were received in the session. With fewer or more edges, `cfg_word_o` keeps its previous value.
- R4: `rd_dat_o` changes only on a rising edge of `rd_clk_i` inside a session. It reads 0 from the opening of the session until the first such edge. The first edge presents bit 11 of the written word.
- R5: Each readback frame starts with the 12 written bits, MSB first. Next comes the revision ID `REV_ID` (default 4'h1), MSB first. The test pattern follows.
- R6: With configuration bit 11 at 0, the test pattern is 240 bits. Its last 56 bits are 30F066012480F6h, MSB first, and all earlier bits are 0. The frame is 256 bits, and the stream is 512 bits.
- R7: With configuration bit 11 at 1, the test pattern is 304 bits. Its last 72 bits are 30F066012480F69055h, MSB first, and all earlier bits are 0. The frame is 320 bits, and the stream is 640 bits.
- R8: The frame is sent twice back to back. The second copy is bit-identical to the first.
- R9: Outside a session, `rd_dat_o` is 0, and the write and read clocks have no effect on `cfg_word_o` or `rd_dat_o`.
- R10: After the two frames, each further read-clock rising edge puts on `rd_dat_o` the value that `daisy_i` had at the previous read-clock rising edge.
- R11: After reset, `cfg_word_o` is `CFG_RST` (default 0) and `rd_dat_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_strobe_i | input | 1 | Session-opening strobe, rising edge active |
| acq_ctl_i | input | 1 | Acquisition control; low qualifies the arm strobe, a rising edge closes the session |
| wr_clk_i | input | 1 | Serial write clock, data taken on falling edge |
| wr_dat_i | input | 1 | Serial write data |
| rd_clk_i | input | 1 | Readback clock, output advances on rising edge |
| daisy_i | input | 1 | Readback output of the next device in the chain |
| rd_dat_o | output | 1 | Readback serial data |
| cfg_word_o | output | 12 | Committed configuration word |

## Verification
A table of write sessions exercises the commit rule. It sends exactly 12 bits, 11 bits, 13 bits and none at all, with words of mixed bit values, so that an MSB-first load is told apart from a reversed one, and a full write from a short or over-long one. Full readback streams are compared bit by bit for one word with bit 11 clear and one with it set. Mismatches are counted separately in the word field, the revision field, the pattern and the second frame, so a wrong frame length or a wrong pattern tail is located. Separate tests cover an arm strobe with acquisition control high, clocks sent outside a session, and the one-clock delay of the daisy-chain input after the stream.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
    localparam int CFG_W     = 12;
    localparam int REV_W     = 4;
    localparam int PAT_LEN0  = 240;
    localparam int PAT_LEN1  = 304;
    localparam int TAIL_W    = 72;
    // Pattern tails, right-aligned; bits above a tail's own length are zero
    localparam logic [TAIL_W-1:0] TAIL0 = 72'h0000_30F0_6601_2480_F6;
    localparam logic [TAIL_W-1:0] TAIL1 = 72'h30_F066_0124_80F6_9055;
endpackage

// File: rtl/cfgreg_edge_detect.sv
module cfgreg_edge_detect #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
        assign fall_o[g] = ~lvl_i[g] & prev_q[g];
    end
endmodule

// File: rtl/cfgreg_readback.sv
module cfgreg_readback import cfgreg_pkg::*; #(
    parameter int              CW     = CFG_W,
    parameter logic [REV_W-1:0] REV_ID = 4'h1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          active_i,
    input  logic          step_i,
    input  logic [CW-1:0] word_i,
    input  logic          daisy_i,
    output logic          sdo_o
);
    localparam int FLEN0 = CW + REV_W + PAT_LEN0;
    localparam int FLEN1 = CW + REV_W + PAT_LEN1;
    localparam int IW    = $clog2(2 * FLEN1 + 1);
    localparam logic [IW-1:0] FL0  = IW'(FLEN0);
    localparam logic [IW-1:0] FL1  = IW'(FLEN1);
    localparam logic [IW-1:0] TOT0 = IW'(2 * FLEN0);
    localparam logic [IW-1:0] TOT1 = IW'(2 * FLEN1);
    localparam logic [IW-1:0] WEND = IW'(CW);
    localparam logic [IW-1:0] REND = IW'(CW + REV_W);

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          chain;
        logic          sdo;
    } rb_t;

    rb_t q, d;

    logic              fmt;
    logic [IW-1:0]     flen, tot, pos, rem;
    logic [CW-1:0]     wsh;
    logic [REV_W-1:0]  rsh;
    logic [TAIL_W-1:0] tsh;
    logic              fbit;

    always_comb begin
        fmt  = word_i[CW-1];
        flen = fmt ? FL1 : FL0;
        tot  = fmt ? TOT1 : TOT0;
        pos  = (q.idx >= flen) ? (q.idx - flen) : q.idx;
        rem  = flen - IW'(1) - pos;
        wsh  = word_i >> (WEND - IW'(1) - pos);
        rsh  = REV_ID >> (REND - IW'(1) - pos);
        tsh  = (fmt ? TAIL1 : TAIL0) >> rem;
        if (pos < WEND)      fbit = wsh[0];
        else if (pos < REND) fbit = rsh[0];
        else                 fbit = tsh[0];

        d = q;
        if (start_i) begin
            d.idx   = '0;
            d.chain = 1'b0;
            d.sdo   = 1'b0;
        end else if (!active_i) begin
            d.idx = '0;
            d.sdo = 1'b0;
        end else if (step_i) begin
            d.chain = daisy_i;
            if (q.idx < tot) begin
                d.sdo = fbit;
                d.idx = q.idx + IW'(1);
            end else begin
                d.sdo = q.chain;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo_o = q.sdo;

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= TOT1);                                                  // R8
    AST_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !step_i && !start_i) |=> $stable(q.sdo));           // R4
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (q.sdo == 1'b0));                                  // R9
    AST_CHAIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && step_i && !start_i && q.idx == tot) |=> (q.sdo == $past(q.chain))); // R10
endmodule

// File: rtl/cfgreg_serial.sv
module cfgreg_serial import cfgreg_pkg::*; #(
    parameter int               CW      = CFG_W,
    parameter logic [REV_W-1:0] REV_ID  = 4'h1,
    parameter logic [CW-1:0]    CFG_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_strobe_i,
    input  logic          acq_ctl_i,
    input  logic          wr_clk_i,
    input  logic          wr_dat_i,
    input  logic          rd_clk_i,
    input  logic          daisy_i,
    output logic          rd_dat_o,
    output logic [CW-1:0] cfg_word_o
);
    localparam int CNT_W = $clog2(CW + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CW);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(CW + 1);

    typedef struct packed {
        logic             sess;
        logic [CNT_W-1:0] cnt;
        logic [CW-1:0]    shreg;
        logic [CW-1:0]    cfg;
    } st_t;

    st_t  q, d;
    logic open_p;

    logic [3:0] lvl, rise, fall;
    logic arm_rise, acq_rise, wr_fall, rd_rise;

    assign lvl = {rd_clk_i, wr_clk_i, acq_ctl_i, arm_strobe_i};

    cfgreg_edge_detect #(.N(4)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign arm_rise = rise[0];
    assign acq_rise = rise[1];
    assign wr_fall  = fall[2];
    assign rd_rise  = rise[3];

    always_comb begin
        d      = q;
        open_p = 1'b0;
        if (arm_rise && !acq_ctl_i) begin
            d.sess  = 1'b1;
            d.cnt   = '0;
            d.shreg = '0;
            open_p  = 1'b1;
        end else if (q.sess && acq_rise) begin
            d.sess = 1'b0;
            if (q.cnt == FULL) d.cfg = q.shreg;
        end else if (q.sess && wr_fall) begin
            if (q.cnt < FULL) begin
                d.shreg = {q.shreg[CW-2:0], wr_dat_i};
                d.cnt   = q.cnt + CNT_W'(1);
            end else begin
                d.cnt = OVER;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cfg   <= CFG_RST;
        end else begin
            q <= d;
        end
    end

    cfgreg_readback #(.CW(CW), .REV_ID(REV_ID)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (open_p),
        .active_i (q.sess),
        .step_i   (rd_rise),
        .word_i   (q.shreg),
        .daisy_i  (daisy_i),
        .sdo_o    (rd_dat_o)
    );

    assign cfg_word_o = q.cfg;

    AST_OPEN_SESS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_rise && !acq_ctl_i) |=> (q.sess && q.cnt == '0));           // R1
    AST_NO_OPEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.sess && arm_rise && acq_ctl_i) |=> !q.sess);                 // R1
    AST_MSB_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sess && wr_fall && q.cnt < FULL && !arm_rise && !acq_rise)
        |=> (q.shreg[0] == $past(wr_dat_i)));                            // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= OVER);                                                  // R3
    AST_PARTIAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sess && acq_rise && q.cnt != FULL) |=> $stable(q.cfg));       // R3
    AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sess && acq_rise && q.cnt == FULL) |=> (q.cfg == $past(q.shreg))); // R3
    AST_HOLD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !q.sess |=> $stable(q.cfg));                                     // R9
endmodule

// File: tb/cfgreg_serial_test.sv
module cfgreg_serial_test;
    localparam int CLK_P = 10;
    localparam logic [55:0] T0 = 56'h30F066012480F6;
    localparam logic [71:0] T1 = 72'h30F066012480F69055;

    // {word, bits to send, expected committed value}
    localparam int NV = 6;
    localparam logic [27:0] VEC [NV] = '{
        {12'hA5C, 4'd12, 12'hA5C},
        {12'h123, 4'd11, 12'hA5C},
        {12'h7FF, 4'd13, 12'hA5C},
        {12'h801, 4'd12, 12'h801},
        {12'h000, 4'd0,  12'h801},
        {12'h5A3, 4'd12, 12'h5A3}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic arm = 1'b0, acq = 1'b0, wclk = 1'b0, wdat = 1'b0, rclk = 1'b0, daisy = 1'b0;
    logic        rdat;
    logic [11:0] cfg;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    cfgreg_serial uut (
        .clk(clk), .rst_n(rst_n), .arm_strobe_i(arm), .acq_ctl_i(acq),
        .wr_clk_i(wclk), .wr_dat_i(wdat), .rd_clk_i(rclk), .daisy_i(daisy),
        .rd_dat_o(rdat), .cfg_word_o(cfg)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic arm_pulse();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
        @(negedge clk);
    endtask

    task automatic acq_pulse();
        @(negedge clk) acq = 1'b1;
        @(negedge clk) acq = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_bit(input logic b);
        @(negedge clk) begin wdat = b; wclk = 1'b1; end
        @(negedge clk) wclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_word(input logic [11:0] w, input int n);
        for (int i = 0; i < n; i++) wr_bit(i < 12 ? w[11-i] : 1'b0);
    endtask

    task automatic rd_pulse(output logic b);
        @(negedge clk) rclk = 1'b1;
        @(negedge clk) rclk = 1'b0;
        b = rdat;
    endtask

    task automatic readback(input logic [11:0] w, input string preq, input bit do_chain);
        logic [319:0] frame, tmp;
        int len;
        int m_cfg = 0, m_rev = 0, m_pat = 0, m_f2 = 0;
        logic b;
        logic [4:0] cv = 5'b10110;
        if (w[11]) begin frame = {w, 4'h1, 232'h0, T1}; len = 320; end
        else begin frame = {64'h0, w, 4'h1, 184'h0, T0}; len = 256; end
        check("R4 output before first read edge", {31'h0, rdat}, 32'h0);
        for (int i = 0; i < 2*len; i++) begin
            int p;
            p = (i >= len) ? i - len : i;
            tmp = frame >> (len - 1 - p);
            rd_pulse(b);
            if (b !== tmp[0]) begin
                if (i >= len)  m_f2++;
                else if (p < 12) m_cfg++;
                else if (p < 16) m_rev++;
                else m_pat++;
            end
        end
        check("R5 word field mismatches", m_cfg, 0);
        check("R5 revision field mismatches", m_rev, 0);
        check({preq, " pattern mismatches"}, m_pat, 0);
        check("R8 second frame mismatches", m_f2, 0);
        if (do_chain) begin
            for (int j = 0; j < 5; j++) begin
                daisy = cv[j];
                rd_pulse(b);
                if (j > 0) check("R10 chain bit delayed one read clock", {31'h0, b}, {31'h0, cv[j-1]});
            end
            daisy = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset config word", {20'h0, cfg}, 32'h0);
        check("R11 reset read data", {31'h0, rdat}, 32'h0);

        // Table walk: R2 MSB-first loading, R3 exact-count commit
        for (int v = 0; v < NV; v++) begin
            arm_pulse();
            wr_word(VEC[v][27:16], int'(VEC[v][15:12]));
            acq_pulse();
            check($sformatf("R3 R2 vector %0d commit", v), {20'h0, cfg}, {20'h0, VEC[v][11:0]});
        end

        // R12-style case under R1: arm while acquisition control high
        @(negedge clk) acq = 1'b1;
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
        @(negedge clk);
        wr_word(12'hFFF, 12);
        @(negedge clk) acq = 1'b0;
        @(negedge clk);
        acq_pulse();
        check("R1 arm with acq high opens nothing", {20'h0, cfg}, 32'h5A3);

        // R9: clocks outside a session
        wr_word(12'h0F0, 12);
        acq_pulse();
        check("R9 write clocks outside session", {20'h0, cfg}, 32'h5A3);
        rd_pulse(b);
        check("R9 read data outside session", {31'h0, b}, 32'h0);

        // Format 0 readback with chain passthrough
        arm_pulse();
        wr_word(12'h3C5, 12);
        readback(12'h3C5, "R6", 1'b1);
        acq_pulse();
        check("R3 commit after readback", {20'h0, cfg}, 32'h3C5);
        check("R9 read data cleared at close", {31'h0, rdat}, 32'h0);

        // Format 1 readback
        arm_pulse();
        wr_word(12'h9A6, 12);
        readback(12'h9A6, "R7", 1'b0);
        acq_pulse();
        check("R3 commit format 1 word", {20'h0, cfg}, 32'h9A6);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule